// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block predicts the next fetch address for the instruction fetch stage before the fetched word has been decoded. Each fetch PC is looked up in a small set-associative table in the same cycle. Every entry carries a full address tag, so a hit means that this exact PC resolved as a taken branch earlier. On a hit the stored target becomes the next fetch address. On a miss, fetch continues sequentially.

The execute stage reports each resolved branch on a resolve port. That report carries the branch PC, the real direction, the real target, and whether the fetch stage got a hit for it. Only taken branches are kept. A taken branch that is not yet buffered is written into the table. A buffered branch that turns out not taken is removed. A buffered branch that went to another target has its target rewritten. In both of those last cases the block raises a mispredict flag, which the pipeline uses to start its own flush. Direction counters, decode and the flush itself sit outside this block.

With `WAYS` set to 1 the table is direct-mapped. With more ways, a new branch goes into an empty way if the set has one, and otherwise replaces a way chosen by a per-set round-robin pointer.

Top module: `branch_target_buffer`

## Requirements
- R1: While reset is active, and after it is released, every entry is invalid, so no lookup hits until a taken branch has been resolved.
- R2: A lookup hits only when the set chosen by PC bits [OFS_W+IDX_W-1:OFS_W] holds a valid entry whose tag equals PC bits [PC_W-1:OFS_W+IDX_W]. On a hit, `fetch_next` equals that entry's stored target.
- R3: On a miss, `fetch_hit` is 0 and `fetch_next` equals `fetch_pc + 2**OFS_W`.
- R4: When a resolve reports a taken branch with `res_hit` at 0, the entry for that PC is written with `res_target`, in place if it is already present. The new entry is visible to lookups from the next cycle on, and `mispredict` stays 0.
- R5: When a resolve reports a not-taken branch with `res_hit` at 1 and the entry is present, the entry is removed and `mispredict` is 1 in that same cycle.
- R6: When a resolve reports a taken branch with `res_hit` at 1 and a target that differs from the stored one, `mispredict` is 1 in that cycle and the stored target is replaced.
- R7: When a resolve reports a taken branch with `res_hit` at 1 and the same target as the stored one, `mispredict` is 0 and the table does not change.
- R8: A resolve that reports not taken with `res_hit` at 0 has no effect: `mispredict` stays 0 and a buffered entry for that PC keeps hitting.
- R9: A new entry goes into the lowest-numbered invalid way of its set. If every way is valid, it replaces the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, after each such replacement.
- R10: A lookup in the same cycle as a resolve that changes the table sees the contents from before the change.
- R11: A resolve with `res_hit` at 1 whose entry is no longer present raises `mispredict`. If it was taken, it is then written as in R4. If it was not taken, the table is left unchanged.
- R12: Two PCs that share a set but differ in any tag bit, including the top bit, are separate entries. The table never holds two valid matches for one PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Fetch address to look up |
| fetch_hit | output | 1 | Lookup found a buffered taken branch |
| fetch_next | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | The branch was taken |
| res_target | input | PC_W | Actual target of the branch |
| res_hit | input | 1 | The fetch stage got a hit for this branch |
| mispredict | output | 1 | The buffered prediction for this resolve was wrong |

## Verification
The lookup result (`fetch_hit`, `fetch_next`) and `mispredict` are combinational, so they are due in the same cycle the inputs are applied. Table updates take effect at the next rising edge and show in lookups one cycle after the resolve. The bench drives inputs on the falling edge and samples the outputs 1 ns later, comparing them with a behavioural model. That model is stepped only after the rising edge, which applies R10 in the same way the design does. A long random phase over a small pool of aliasing addresses exercises replacement order and target rewrites against the same model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_DROP  = 2'd2
  } res_act_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_set,
  input  logic [WAY_W-1:0]               wr_way,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [PC_W-1:0]                wr_tgt,
  input  logic                           del_en,
  input  logic [IDX_W-1:0]               del_set,
  input  logic [WAY_W-1:0]               del_way,
  input  logic [IDX_W-1:0]               rd_set_a,
  output logic [WAYS-1:0]                rd_vld_a,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag_a,
  output logic [WAYS-1:0][PC_W-1:0]      rd_tgt_a,
  input  logic [IDX_W-1:0]               rd_set_b,
  output logic [WAYS-1:0]                rd_vld_b,
  output logic [WAYS-1:0][TAG_W-1:0]     rd_tag_b,
  output logic [WAYS-1:0][PC_W-1:0]      rd_tgt_b
);
  logic [SETS-1:0][WAYS-1:0]             vld_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][PC_W-1:0]   tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_set][wr_way]   <= 1'b1;
      if (del_en) vld_q[del_set][del_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      tgt_q[wr_set][wr_way] <= wr_tgt;
    end
  end

  always_comb begin
    rd_vld_a = vld_q[rd_set_a];
    rd_tag_a = tag_q[rd_set_a];
    rd_tgt_a = tgt_q[rd_set_a];
    rd_vld_b = vld_q[rd_set_b];
    rd_tag_b = tag_q[rd_set_b];
    rd_tgt_b = tgt_q[rd_set_b];
  end
endmodule

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
  input  logic [WAYS-1:0][PC_W-1:0]   tgt_i,
  input  logic [TAG_W-1:0]            key_i,
  output logic [WAYS-1:0]             hit_vec_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o,
  output logic [PC_W-1:0]             hit_tgt_o
);
  always_comb begin
    hit_way_o = '0;
    hit_tgt_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec_o[w] = vld_i[w] && (tag_i[w] == key_i);
      if (hit_vec_o[w]) begin
        hit_way_o = WAY_W'(w);
        hit_tgt_o = hit_tgt_o | tgt_i[w];
      end
    end
    hit_o = |hit_vec_o;
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAYS-1:0]  vld_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  assign full_o = &vld_i;

  generate
    if (WAYS == 1) begin : g_direct
      assign way_o = '0;
    end else begin : g_assoc
      logic [SETS-1:0][WAY_W-1:0] rr_q;
      logic [WAY_W-1:0]           free_way;

      always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
          if (!vld_i[w]) free_way = WAY_W'(w);
        end
      end

      assign way_o = full_o ? rr_q[set_i] : free_way;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rr_q <= '0;
        end else if (adv_i) begin
          if (rr_q[set_i] == WAY_W'(WAYS - 1)) rr_q[set_i] <= '0;
          else                                 rr_q[set_i] <= rr_q[set_i] + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int PC_W  = 32,
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic [PC_W-1:0] fetch_next,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_hit,
  output logic            mispredict
);
  import btb_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [IDX_W-1:0] set_of(input logic [PC_W-1:0] pc);
    return pc[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction

  function automatic logic [PC_W-1:0] seq_of(input logic [PC_W-1:0] pc);
    return pc + PC_W'(2 ** OFS_W);
  endfunction

  logic [WAYS-1:0]             lk_vld, rs_vld;
  logic [WAYS-1:0][TAG_W-1:0]  lk_tag, rs_tag;
  logic [WAYS-1:0][PC_W-1:0]   lk_tgt, rs_tgt;
  logic [WAYS-1:0]             lk_hit_vec, rs_hit_vec;
  logic                        lk_hit, rs_match;
  logic [WAY_W-1:0]            lk_way, rs_way, vic_way;
  logic [PC_W-1:0]             lk_target, rs_stored;
  logic                        set_full;
  logic                        same_target;
  res_act_e                    act;
  logic                        wr_evt, del_evt, evict_evt;
  logic [WAY_W-1:0]            wr_way;

  btb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PC_W(PC_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_evt),
    .wr_set   (set_of(res_pc)),
    .wr_way   (wr_way),
    .wr_tag   (tag_of(res_pc)),
    .wr_tgt   (res_target),
    .del_en   (del_evt),
    .del_set  (set_of(res_pc)),
    .del_way  (rs_way),
    .rd_set_a (set_of(fetch_pc)),
    .rd_vld_a (lk_vld),
    .rd_tag_a (lk_tag),
    .rd_tgt_a (lk_tgt),
    .rd_set_b (set_of(res_pc)),
    .rd_vld_b (rs_vld),
    .rd_tag_b (rs_tag),
    .rd_tgt_b (rs_tgt)
  );

  btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PC_W(PC_W)) fetch_match_i (
    .vld_i     (lk_vld),
    .tag_i     (lk_tag),
    .tgt_i     (lk_tgt),
    .key_i     (tag_of(fetch_pc)),
    .hit_vec_o (lk_hit_vec),
    .hit_o     (lk_hit),
    .hit_way_o (lk_way),
    .hit_tgt_o (lk_target)
  );

  btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PC_W(PC_W)) res_match_i (
    .vld_i     (rs_vld),
    .tag_i     (rs_tag),
    .tgt_i     (rs_tgt),
    .key_i     (tag_of(res_pc)),
    .hit_vec_o (rs_hit_vec),
    .hit_o     (rs_match),
    .hit_way_o (rs_way),
    .hit_tgt_o (rs_stored)
  );

  btb_victim #(.SETS(SETS), .WAYS(WAYS)) victim_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_of(res_pc)),
    .vld_i  (rs_vld),
    .adv_i  (evict_evt),
    .way_o  (vic_way),
    .full_o (set_full)
  );

  assign fetch_hit  = lk_hit;
  assign fetch_next = lk_hit ? lk_target : seq_of(fetch_pc);

  assign same_target = rs_match && (rs_stored == res_target);

  always_comb begin
    act = ACT_NONE;
    if (res_valid) begin
      if (!res_taken) begin
        if (res_hit && rs_match) act = ACT_DROP;
      end else if (!(res_hit && same_target)) begin
        act = ACT_WRITE;
      end
    end
  end

  assign mispredict = res_valid && res_hit && (!res_taken || !same_target);
  assign wr_evt     = rst_n && (act == ACT_WRITE);
  assign del_evt    = rst_n && (act == ACT_DROP);
  assign evict_evt  = wr_evt && !rs_match && set_full;
  assign wr_way     = rs_match ? rs_way : vic_way;

  logic unused_ok;
  assign unused_ok = ^{lk_way, rs_hit_vec};
endmodule

// File: rtl/branch_target_buffer_chk.sv
module branch_target_buffer_chk #(
  parameter int PC_W  = 32,
  parameter int WAYS  = 2,
  parameter int OFS_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_hit,
  input logic [PC_W-1:0] fetch_next,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            res_hit,
  input logic            mispredict,
  input logic [WAYS-1:0] lk_hit_vec,
  input logic            wr_evt,
  input logic            del_evt
);
  assert_unique_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  assert_seq_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_hit |-> fetch_next == fetch_pc + PC_W'(2 ** OFS_W));

  assert_flag_scope_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> res_valid && res_hit);

  assert_drop_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(del_evt) && fetch_pc == $past(res_pc)) |-> !fetch_hit);

  assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_evt) && fetch_pc == $past(res_pc)) |-> (fetch_hit && fetch_next == $past(res_target)));

  assert_quiet_confirm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && res_taken && !mispredict) |-> (!wr_evt && !del_evt));

  assert_notaken_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !res_hit) |-> (!wr_evt && !del_evt && !mispredict));
endmodule

bind branch_target_buffer branch_target_buffer_chk #(
  .PC_W(PC_W), .WAYS(WAYS), .OFS_W(OFS_W)
) chk_i (.*);

// File: tb/branch_target_buffer_tb_top.sv
module branch_target_buffer_tb_top;
  localparam int PC_W  = 32;
  localparam int SETS  = 16;
  localparam int WAYS  = 2;
  localparam int OFS_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            fetch_hit;
  logic [PC_W-1:0] fetch_next;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_taken = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic            res_hit = 1'b0;
  logic            mispredict;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .fetch_next(fetch_next), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_hit(res_hit),
    .mispredict(mispredict)
  );

  // Behavioural reference: each slot remembers the word address it holds.
  bit              m_vld [SETS][WAYS];
  logic [PC_W-1:0] m_word[SETS][WAYS];
  logic [PC_W-1:0] m_tgt [SETS][WAYS];
  int              m_rr  [SETS];

  function automatic int m_set(input logic [PC_W-1:0] pc);
    return int'((pc >> OFS_W) % SETS);
  endfunction

  function automatic int m_find(input logic [PC_W-1:0] pc);
    int s = m_set(pc);
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_word[s][w] == (pc >> OFS_W)) return w;
    return -1;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
    end
  endtask

  task automatic m_apply(input bit rv, input logic [PC_W-1:0] rpc, input bit rt,
                         input logic [PC_W-1:0] rtg, input bit rh);
    int s = m_set(rpc);
    int f = m_find(rpc);
    int slot;
    if (!rv) return;
    if (!rt) begin
      if (rh && f >= 0) m_vld[s][f] = 1'b0;
      return;
    end
    if (rh && f >= 0 && m_tgt[s][f] == rtg) return;
    if (f >= 0) slot = f;
    else begin
      slot = -1;
      for (int w = 0; w < WAYS; w++) if (!m_vld[s][w] && slot < 0) slot = w;
      if (slot < 0) begin
        slot = m_rr[s];
        m_rr[s] = (m_rr[s] + 1) % WAYS;
      end
    end
    m_vld[s][slot]  = 1'b1;
    m_word[s][slot] = rpc >> OFS_W;
    m_tgt[s][slot]  = rtg;
  endtask

  task automatic check(input string req, input string what, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, compare 1 ns later, advance model after rising edge.
  task automatic step(input string req, input logic [PC_W-1:0] fpc,
                      input bit rv, input logic [PC_W-1:0] rpc, input bit rt,
                      input logic [PC_W-1:0] rtg, input bit rh);
    int f, s, rf;
    bit exp_hit, exp_mis;
    logic [PC_W-1:0] exp_next;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
    res_target = rtg; res_hit = rh;
    #1;
    f = m_find(fpc);
    s = m_set(fpc);
    exp_hit  = (f >= 0);
    exp_next = exp_hit ? m_tgt[s][f] : fpc + PC_W'(2 ** OFS_W);
    rf = m_find(rpc);
    exp_mis = rv && rh && (!rt || rf < 0 || m_tgt[m_set(rpc)][rf] != rtg);
    check(req, "fetch_hit", PC_W'(fetch_hit), PC_W'(exp_hit));
    check(req, "fetch_next", fetch_next, exp_next);
    check(req, "mispredict", PC_W'(mispredict), PC_W'(exp_mis));
    @(posedge clk);
    m_apply(rv, rpc, rt, rtg, rh);
  endtask

  task automatic look(input string req, input logic [PC_W-1:0] fpc);
    step(req, fpc, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  localparam logic [PC_W-1:0] PA = 32'h0000_1010;
  localparam logic [PC_W-1:0] PB = 32'h0000_2010;
  localparam logic [PC_W-1:0] PC = 32'h0000_3010;
  localparam logic [PC_W-1:0] PD = 32'h0000_4010;
  localparam logic [PC_W-1:0] PH = 32'h8000_1010;

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "hit in reset", PC_W'(fetch_hit), '0);
    @(negedge clk); rst_n = 1'b1;
    look("R1", PA);
    look("R3", 32'h0000_1014);
    // R10: lookup sees old contents while A is written
    step("R10", PA, 1'b1, PA, 1'b1, 32'h0000_0800, 1'b0);
    look("R4", PA);
    look("R2", PA + 32'h4);
    step("R9", PB, 1'b1, PB, 1'b1, 32'h0000_0900, 1'b0);
    look("R9", PB);
    look("R9", PA);
    step("R9", PC, 1'b1, PC, 1'b1, 32'h0000_0A00, 1'b0);
    look("R9", PA);
    look("R9", PC);
    step("R9", PD, 1'b1, PD, 1'b1, 32'h0000_0D00, 1'b0);
    look("R9", PB);
    look("R9", PD);
    step("R7", PC, 1'b1, PC, 1'b1, 32'h0000_0A00, 1'b1);
    look("R7", PC);
    step("R6", PC, 1'b1, PC, 1'b1, 32'h0000_0B00, 1'b1);
    look("R6", PC);
    step("R5", PD, 1'b1, PD, 1'b0, '0, 1'b1);
    look("R5", PD);
    step("R8", PC, 1'b1, PC, 1'b0, '0, 1'b0);
    look("R8", PC);
    step("R11", PA, 1'b1, PA, 1'b0, '0, 1'b1);
    look("R11", PA);
    step("R11", PB, 1'b1, PB, 1'b1, 32'h0000_0C00, 1'b1);
    look("R11", PB);
    step("R12", PH, 1'b1, PH, 1'b1, 32'h0000_0E00, 1'b0);
    look("R12", PH);
    look("R12", PA);
    look("R12", PB);
    // Random phase over aliasing addresses in two sets
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] fp, rp, tg;
      fp = {$urandom_range(0, 5), 8'h0, 2'($urandom_range(0, 1)), 4'h0} | 32'h10;
      rp = {$urandom_range(0, 5), 8'h0, 2'($urandom_range(0, 1)), 4'h0} | 32'h10;
      tg = {24'h0, 2'($urandom_range(0, 3)), 6'h0};
      step("R2", fp, 1'($urandom_range(0, 1)), rp, 1'($urandom_range(0, 1)), tg,
           (m_find(rp) >= 0) ? 1'($urandom_range(0, 3) != 0) : 1'($urandom_range(0, 7) == 0));
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule